// File: doc/BRIEF.md
# Partial-Word Frequent-Value Bus Encoder

This block sits on the transmit side of a 32-bit off-chip data bus and recodes each outgoing word so that fewer bus wires toggle. It keeps three small history tables: one of whole words, one of the upper 20-bit field, and one of the lower 12-bit field. Each table has one entry per bus line of the part of the bus it codes. When a word or one of its fields was seen recently, the block sends a one-hot index in place of the value. Because every wire is then XORed with its previous level, each coded field costs a single wire toggle.

A single encode line tells the receiver whether the bus carries a code. The receiver can tell which fields are coded from the bit pattern alone. A coded field shows exactly one toggled wire. A field sent raw beside a coded field always holds at least two ones. Every accepted word updates all three tables in the same way, so a matching receiver can keep identical state. The output is registered, one cycle after the input word.

Top module: `fv_split_bus_encoder`

## Requirements
- R1: Reset drives bus_out to all zeros, enc_out low and out_valid low, and marks every table entry invalid. An invalid entry never hits, so the first word after reset is always sent raw.
- R2: A word accepted with in_valid high appears on bus_out one clock later, with out_valid high. A cycle with in_valid low yields out_valid low the next cycle, and bus_out and enc_out keep their levels.
- R3: If no table hits, enc_out is low and the new bus_out is the previous bus_out XOR the input word.
- R4: A whole-word hit at index f takes priority over any field hit. The code is the 32-bit value with only bit f set, and enc_out is high.
- R5: With no whole-word hit, if the upper field hits at index h and the lower field hits at index l, the code has bit 12+h and bit l set and no other bits. enc_out is high.
- R6: If only the upper field hits (index h) and the raw lower field has two or more ones, the code is bit 12+h in the upper field, with the lower field sent raw. enc_out is high.
- R7: If only the lower field hits (index l) and the raw upper field has two or more ones, the code is the upper field sent raw, with only bit l set in the lower field. enc_out is high.
- R8: A single-field hit whose other field holds fewer than two ones is sent raw, with enc_out low.
- R9: Every accepted word updates all three tables. A hit makes that entry the most recently used. A miss writes the value into the least recently used entry. After reset the recency order has the highest index as least recent, so an empty table fills from its highest index downward.
- R10: bus_out toggles by the code, so it becomes the previous bus_out XOR the code. enc_out is a plain level with no XOR stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 32 | Word to send |
| out_valid | output | 1 | A new word was driven on bus_out this cycle |
| bus_out | output | 32 | Transition-coded bus wires |
| enc_out | output | 1 | High when the current bus word carries a code |

## Verification
Some properties are checked on every cycle. These are the one-cycle latency, the hold of the bus during idle cycles, and the XOR relation between a raw word and the bus toggles. A fourth check covers the structure of any coded word: at least one field toggles exactly one wire. Which index is chosen, which table takes priority, the two-ones rule and the recency order all depend on table history. Only the bench can show these, by comparing against its own table model. Its stimulus is random words drawn from small field pools, plus directed partial-repeat and reset scenarios.

// File: rtl/fv_split_bus_encoder.sv
module fv_split_bus_encoder #(
  parameter int W    = 32,
  parameter int HI_W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] bus_out,
  output logic         enc_out
);
  localparam int LO_W = W - HI_W;
  localparam int FRW  = $clog2(W);
  localparam int HRW  = $clog2(HI_W);
  localparam int LRW  = $clog2(LO_W);
  localparam logic [FRW-1:0] F_LAST = FRW'(W - 1);
  localparam logic [HRW-1:0] H_LAST = HRW'(HI_W - 1);
  localparam logic [LRW-1:0] L_LAST = LRW'(LO_W - 1);

  logic [W-1:0]    f_tab [W];
  logic [FRW-1:0]  f_rank [W];
  logic [W-1:0]    f_vld;
  logic [HI_W-1:0] h_tab [HI_W];
  logic [HRW-1:0]  h_rank [HI_W];
  logic [HI_W-1:0] h_vld;
  logic [LO_W-1:0] l_tab [LO_W];
  logic [LRW-1:0]  l_rank [LO_W];
  logic [LO_W-1:0] l_vld;

  wire [HI_W-1:0] hi = in_data[W-1:LO_W];
  wire [LO_W-1:0] lo = in_data[LO_W-1:0];

  logic           f_hit, h_hit, l_hit;
  logic [FRW-1:0] f_idx, f_vic, f_ref, f_ref_rank;
  logic [HRW-1:0] h_idx, h_vic, h_ref, h_ref_rank;
  logic [LRW-1:0] l_idx, l_vic, l_ref, l_ref_rank;

  always_comb begin
    f_hit = 1'b0; f_idx = '0; f_vic = '0;
    for (int i = 0; i < W; i++) begin
      if (f_vld[i] && f_tab[i] == in_data) begin f_hit = 1'b1; f_idx = FRW'(i); end
      if (f_rank[i] == F_LAST) f_vic = FRW'(i);
    end
    h_hit = 1'b0; h_idx = '0; h_vic = '0;
    for (int i = 0; i < HI_W; i++) begin
      if (h_vld[i] && h_tab[i] == hi) begin h_hit = 1'b1; h_idx = HRW'(i); end
      if (h_rank[i] == H_LAST) h_vic = HRW'(i);
    end
    l_hit = 1'b0; l_idx = '0; l_vic = '0;
    for (int i = 0; i < LO_W; i++) begin
      if (l_vld[i] && l_tab[i] == lo) begin l_hit = 1'b1; l_idx = LRW'(i); end
      if (l_rank[i] == L_LAST) l_vic = LRW'(i);
    end
  end

  assign f_ref = f_hit ? f_idx : f_vic;
  assign h_ref = h_hit ? h_idx : h_vic;
  assign l_ref = l_hit ? l_idx : l_vic;
  assign f_ref_rank = f_rank[f_ref];
  assign h_ref_rank = h_rank[h_ref];
  assign l_ref_rank = l_rank[l_ref];

  wire [W-1:0]    f_oh = {{(W-1){1'b0}}, 1'b1} << f_idx;
  wire [HI_W-1:0] h_oh = {{(HI_W-1){1'b0}}, 1'b1} << h_idx;
  wire [LO_W-1:0] l_oh = {{(LO_W-1){1'b0}}, 1'b1} << l_idx;
  wire hi_multi = $countones(hi) >= 2;
  wire lo_multi = $countones(lo) >= 2;

  logic [W-1:0] code;
  logic         enc;
  always_comb begin
    code = in_data;
    enc  = 1'b1;
    if (f_hit)                    code = f_oh;
    else if (h_hit && l_hit)      code = {h_oh, l_oh};
    else if (h_hit && lo_multi)   code = {h_oh, lo};
    else if (l_hit && hi_multi)   code = {hi, l_oh};
    else                          enc  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      bus_out   <= '0;
      enc_out   <= 1'b0;
      f_vld     <= '0;
      h_vld     <= '0;
      l_vld     <= '0;
      for (int i = 0; i < W; i++)    f_rank[i] <= FRW'(i);
      for (int i = 0; i < HI_W; i++) h_rank[i] <= HRW'(i);
      for (int i = 0; i < LO_W; i++) l_rank[i] <= LRW'(i);
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        bus_out <= bus_out ^ code;
        enc_out <= enc;
        for (int i = 0; i < W; i++)
          if (FRW'(i) == f_ref) begin f_rank[i] <= '0; f_vld[i] <= 1'b1; end
          else if (f_rank[i] < f_ref_rank) f_rank[i] <= f_rank[i] + 1'b1;
        for (int i = 0; i < HI_W; i++)
          if (HRW'(i) == h_ref) begin h_rank[i] <= '0; h_vld[i] <= 1'b1; end
          else if (h_rank[i] < h_ref_rank) h_rank[i] <= h_rank[i] + 1'b1;
        for (int i = 0; i < LO_W; i++)
          if (LRW'(i) == l_ref) begin l_rank[i] <= '0; l_vld[i] <= 1'b1; end
          else if (l_rank[i] < l_ref_rank) l_rank[i] <= l_rank[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && in_valid) begin
      f_tab[f_ref] <= in_data;
      h_tab[h_ref] <= hi;
      l_tab[l_ref] <= lo;
    end
  end
endmodule

// File: rtl/fv_split_bus_encoder_chk.sv
module fv_split_bus_encoder_chk #(
  parameter int W    = 32,
  parameter int LO_W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic [W-1:0] bus_out,
  input logic         enc_out
);
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(bus_out) && $stable(enc_out))); // R2

  AST_RAW_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !enc_out) |-> ((bus_out ^ $past(bus_out)) == $past(in_data))); // R3

  AST_CODED_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && enc_out) |->
      ($countones(bus_out[W-1:LO_W] ^ $past(bus_out[W-1:LO_W])) == 1 ||
       $countones(bus_out[LO_W-1:0] ^ $past(bus_out[LO_W-1:0])) == 1)); // R10
endmodule

bind fv_split_bus_encoder fv_split_bus_encoder_chk #(.W(W), .LO_W(LO_W)) u_chk (.*);

// File: tb/tb_fv_split_bus_encoder.sv
module tb_fv_split_bus_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32, HI_W = 20, LO_W = 12;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_valid, enc_out;
  logic [W-1:0] bus_out;

  fv_split_bus_encoder #(.W(W), .HI_W(HI_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_bus = '0;
  logic exp_enc = 1'b0;

  // table model: 0 whole word, 1 upper field, 2 lower field
  logic [W-1:0] mval [3][W];
  bit mvld [3][W];
  int mstamp [3][W];
  int msize [3];
  int now;

  function automatic int find(int t, logic [W-1:0] key);
    int r = -1;
    for (int i = 0; i < msize[t]; i++) if (mvld[t][i] && mval[t][i] == key) r = i;
    return r;
  endfunction

  function automatic int oldest(int t);
    int r = 0;
    for (int i = 1; i < msize[t]; i++) if (mstamp[t][i] < mstamp[t][r]) r = i;
    return r;
  endfunction

  task automatic touch(int t, logic [W-1:0] key);
    int k = find(t, key);
    if (k < 0) k = oldest(t);
    mval[t][k] = key; mvld[t][k] = 1'b1; mstamp[t][k] = now; now++;
  endtask

  task automatic model_reset();
    msize[0] = W; msize[1] = HI_W; msize[2] = LO_W; now = 1;
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < W; i++) begin mvld[t][i] = 1'b0; mstamp[t][i] = -i; mval[t][i] = '0; end
  endtask

  task automatic model_word(logic [W-1:0] w, output logic [W-1:0] code,
                            output logic enc, output string tag);
    logic [HI_W-1:0] h = w[W-1:LO_W];
    logic [LO_W-1:0] l = w[LO_W-1:0];
    int fi = find(0, w), hi_i = find(1, W'(h)), li = find(2, W'(l));
    enc = 1'b1;
    if (fi >= 0) begin code = W'(1) << fi; tag = "R4"; end
    else if (hi_i >= 0 && li >= 0) begin
      code = (W'(1) << (LO_W + hi_i)) | (W'(1) << li); tag = "R5";
    end else if (hi_i >= 0 && $countones(l) >= 2) begin
      code = (W'(1) << (LO_W + hi_i)) | W'(l); tag = "R6";
    end else if (li >= 0 && $countones(h) >= 2) begin
      code = {h, LO_W'(1) << li}; tag = "R7";
    end else begin
      code = w; enc = 1'b0;
      tag = (hi_i >= 0 || li >= 0) ? "R8" : "R3";
    end
    touch(0, w); touch(1, W'(h)); touch(2, W'(l));
  endtask

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [W-1:0] w, string extra);
    logic [W-1:0] code; logic enc; string tag;
    model_word(w, code, enc, tag);
    exp_bus = exp_bus ^ code; exp_enc = enc;
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    chk(bus_out == exp_bus, {tag, " R10 bus ", extra}, bus_out, exp_bus);
    chk(enc_out == exp_enc, {tag, " enc ", extra}, W'(enc_out), W'(exp_enc));
    chk(out_valid == 1'b1, "R2 out_valid", W'(out_valid), W'(1));
  endtask

  task automatic idle();
    in_valid = 1'b0; in_data = W'($urandom);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 idle valid", W'(out_valid), '0);
    chk(bus_out == exp_bus && enc_out == exp_enc, "R2 idle hold", bus_out, exp_bus);
  endtask

  task automatic do_reset();
    in_valid = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset(); exp_bus = '0; exp_enc = 1'b0;
    chk(bus_out == '0, "R1 bus reset", bus_out, '0);
    chk(enc_out == 1'b0 && out_valid == 1'b0, "R1 flags reset",
        W'({enc_out, out_valid}), '0);
  endtask

  logic [HI_W-1:0] hpool [24];
  logic [LO_W-1:0] lpool [16];

  initial begin
    logic [W-1:0] a;
    void'($urandom(32'd7781));
    model_reset();
    @(negedge clk);
    do_reset();

    a = 32'h12345_678;
    send(a, "R1 first word raw");
    send(a, "R4 repeat");
    send({a[31:12], 12'h0C3}, "R6 upper only");
    send({a[31:12], 12'h010}, "R8 single one in lower");
    send({20'hF0F0F, a[11:0]}, "R7 lower only");
    send({20'hF0F0F, 12'h0C3}, "R5 both fields");
    send({20'h00800, 12'h678}, "R8 single one in upper");
    idle();
    send({20'hF0F0F, 12'h0C3}, "R4 priority over fields");

    for (int i = 0; i < LO_W + 2; i++) send({20'hA0000 + 20'(i * 3), 12'h300 + 12'(i)}, "R9 fill lower");
    send({20'h55555, 12'h300}, "R9 evicted lower");
    send({20'h55555, 12'h30D}, "R9 recent lower");

    do_reset();
    send(a, "R1 table cleared");
    send(a, "R9 refill");

    for (int i = 0; i < 24; i++) hpool[i] = HI_W'($urandom);
    for (int i = 0; i < 16; i++) lpool[i] = LO_W'($urandom);
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) idle();
      else if (r == 1) send(W'($urandom), "random");
      else send({hpool[$urandom_range(0, 23)], lpool[$urandom_range(0, 15)]}, "pool");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule